// File: doc/BRIEF.md
# Text-mode pixel pipeline

This block turns a screen of character codes into a serial monochrome pixel stream for a text display of 80 columns by 30 rows, each character cell 8 pixels wide and 16 scan lines tall. It runs on the pixel clock and is told where the visible area lies by two active-high blanking inputs, one horizontal and one vertical. Sync generation and colour belong elsewhere.

Internally a column counter and a row counter form a 12-bit frame-buffer address: the row sits in bits [11:7] and the column in bits [6:0], so columns 80 to 127 of every row are simply unused storage. A synchronous frame-buffer array, writable through a simple write port, returns the 8-bit code at that address. That code, the 4-bit scan line and a one-bit character-set select together index a generated glyph table. Its 8-bit output is loaded into a shift register once per character and shifted out most significant bit first, one pixel per clock. The frame-buffer address always points one character ahead of the character being shown, so the next glyph byte is ready when the load comes.

A small line state machine has two states. BLANK is the reset state and is held while either blanking input is high. Transition START goes from BLANK to ACTIVE on the first clock edge at which both blanking inputs are low. ACTIVE counts pixel phases 0 to 7 inside each character. Transition LINE_END goes from ACTIVE back to BLANK on the first edge at which either blanking input is high. Both states otherwise hold. Horizontal blanking must last at least two clocks so that the prefetch of column 0 completes.

Top module: `textpix_top`

## Requirements
- R1: While reset is asserted, pix is 0, load_n is 1, fb_addr is 0 and the scan-line field glyph_addr[3:0] is 0.
- R2: fb_addr is {row[4:0], col[6:0]}. During phases 1 to 7 of on-screen character k of a line, col is (k+1) mod 80, so the count goes from 79 back to 0. fb_addr does not change across any clock edge at which load_n is 1 and both blanking inputs are low.
- R3: load_n is 0 in two kinds of cycle: the last BLANK cycle before START (both blanks low), and phase 7 of each ACTIVE character while both blanks stay low. In every other cycle it is 1. At the edge where load_n is 0, col advances by one, wrapping from 79 to 0.
- R4: In the first ACTIVE cycle after START, pix shows bit 7 of the glyph byte of column 0. In phase p of character k it shows bit 7-p of the glyph of column k.
- R5: glyph_addr is {charset_sel, code, scan}. The glyph byte for select 0 is code XOR {scan, scan}. For select 1 it is {code[3:0], code[7:4]} XOR {4'b0000, scan}.
- R6: At each LINE_END, scan increments. When scan wraps from 15 to 0, row increments.
- R7: The row count wraps from 29 to 0, so the 481st active line shows row 0, scan 0.
- R8: pix is 0 in any cycle in which hblank or vblank is high. While vblank is high no START occurs, load_n stays 1, col stays 0, and scan and row are unchanged.
- R9: A frame-buffer write and a read of the same address in the same cycle return the old data to the read. The code shown for character k+1 includes writes made up to phase 5 of character k, and excludes writes made in phase 6 or 7.
- R10: col returns to 0 at LINE_END, so every line starts at column 0 of the current row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hblank | input | 1 | Horizontal blanking, active high |
| vblank | input | 1 | Vertical blanking, active high |
| charset_sel | input | 1 | Static character-set select |
| wr_en | input | 1 | Frame-buffer write enable |
| wr_addr | input | 12 | Frame-buffer write address {row, col} |
| wr_data | input | 8 | Character code to write |
| pix | output | 1 | Serial pixel |
| load_n | output | 1 | Shift-register load strobe, active low |
| fb_addr | output | 12 | Current frame-buffer read address |
| glyph_addr | output | 13 | Current glyph-table index {select, code, scan} |

## Verification
The frame-buffer write port and the one-character-ahead fetch can touch the same cell in the same cycle. The case that matters is a write that lands just before the glyph load. On one full line the bench rewrites the cell of the next character once in phase 6 and once in phase 5. It expects the old code to be displayed in the first case and the new code in the second. Both expectations are computed from a bench-side copy of the memory that is captured at the phase-6 boundary. The same line checks every pixel, the column wrap from 79 to 0 and the load strobe timing. This shows whether the read-first ordering and the load edge line up as stated.

// File: rtl/textpix_pkg.sv
package textpix_pkg;

    localparam int DEF_COLS    = 80;
    localparam int DEF_ROWS    = 30;
    localparam int DEF_COL_W   = 7;
    localparam int DEF_ROW_W   = 5;
    localparam int DEF_SCAN_W  = 4;
    localparam int DEF_CODE_W  = 8;
    localparam int DEF_GLYPH_W = 8;

    typedef enum logic {
        ST_BLANK  = 1'b0,
        ST_ACTIVE = 1'b1
    } line_state_e;

endpackage

// File: rtl/textpix_timing.sv
module textpix_timing
    import textpix_pkg::*;
#(
    parameter int COLS    = DEF_COLS,
    parameter int ROWS    = DEF_ROWS,
    parameter int COL_W   = DEF_COL_W,
    parameter int ROW_W   = DEF_ROW_W,
    parameter int SCAN_W  = DEF_SCAN_W,
    parameter int GLYPH_W = DEF_GLYPH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank,
    input  logic              vblank,
    output logic              load,
    output logic              active,
    output logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  row,
    output logic [SCAN_W-1:0] scan
);

    localparam int              PH_W      = $clog2(GLYPH_W);
    localparam logic [PH_W-1:0] PH_LAST   = PH_W'(GLYPH_W - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    line_state_e       state_q, state_d;
    logic [PH_W-1:0]   phase_q;
    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [SCAN_W-1:0] scan_q;
    logic              visible;
    logic              line_end;

    assign visible = !hblank && !vblank;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START and LINE_END
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK:  if (visible)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (!visible) state_d = ST_BLANK;
        endcase
    end

    // state outputs
    always_comb begin
        load     = 1'b0;
        active   = 1'b0;
        line_end = 1'b0;
        unique case (state_q)
            ST_BLANK: begin
                load = visible;
            end
            ST_ACTIVE: begin
                active   = 1'b1;
                load     = visible && (phase_q == PH_LAST);
                line_end = !visible;
            end
        endcase
    end

    // phase, column, scan-line and row counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            col_q   <= '0;
            row_q   <= '0;
            scan_q  <= '0;
        end else if (line_end) begin
            phase_q <= '0;
            col_q   <= '0;
            scan_q  <= scan_q + 1'b1;
            if (scan_q == {SCAN_W{1'b1}}) begin
                row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end
        end else begin
            if (active) begin
                phase_q <= phase_q + 1'b1;
            end
            if (load) begin
                col_q <= (col_q == COL_LAST) ? '0 : col_q + 1'b1;
            end
        end
    end

    assign col  = col_q;
    assign row  = row_q;
    assign scan = scan_q;

endmodule

// File: rtl/textpix_fbuf.sv
module textpix_fbuf #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // read-first: a same-cycle write is seen one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/textpix_glyph.sv
module textpix_glyph #(
    parameter int CODE_W  = 8,
    parameter int SCAN_W  = 4,
    parameter int GLYPH_W = 8
) (
    input  logic              set_sel,
    input  logic [CODE_W-1:0] code,
    input  logic [SCAN_W-1:0] scan,
    output logic [GLYPH_W-1:0] bits
);

    localparam int HALF = CODE_W / 2;
    localparam int REP  = CODE_W / SCAN_W;

    logic [CODE_W-1:0] set0_row;
    logic [CODE_W-1:0] set1_row;

    // generated table contents for each character set
    assign set0_row = code ^ CODE_W'({REP{scan}});
    assign set1_row = {code[HALF-1:0], code[CODE_W-1:HALF]} ^ CODE_W'(scan);

    assign bits = GLYPH_W'(set_sel ? set1_row : set0_row);

endmodule

// File: rtl/textpix_shift.sv
module textpix_shift #(
    parameter int GLYPH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               active,
    input  logic               hblank,
    input  logic               vblank,
    input  logic [GLYPH_W-1:0] glyph,
    output logic               pix
);

    logic [GLYPH_W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= glyph;
        end else if (active) begin
            sreg_q <= {sreg_q[GLYPH_W-2:0], 1'b0};
        end
    end

    assign pix = sreg_q[GLYPH_W-1] && active && !hblank && !vblank;

endmodule

// File: rtl/textpix_top.sv
module textpix_top
    import textpix_pkg::*;
#(
    parameter int COLS    = DEF_COLS,
    parameter int ROWS    = DEF_ROWS,
    parameter int COL_W   = DEF_COL_W,
    parameter int ROW_W   = DEF_ROW_W,
    parameter int SCAN_W  = DEF_SCAN_W,
    parameter int CODE_W  = DEF_CODE_W,
    parameter int GLYPH_W = DEF_GLYPH_W,
    localparam int FB_AW  = ROW_W + COL_W,
    localparam int GA_W   = 1 + CODE_W + SCAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              charset_sel,
    input  logic              wr_en,
    input  logic [FB_AW-1:0]  wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic              pix,
    output logic              load_n,
    output logic [FB_AW-1:0]  fb_addr,
    output logic [GA_W-1:0]   glyph_addr
);

    logic               load;
    logic               active;
    logic [COL_W-1:0]   col;
    logic [ROW_W-1:0]   row;
    logic [SCAN_W-1:0]  scan;
    logic [CODE_W-1:0]  code_q;
    logic [GLYPH_W-1:0] glyph;

    textpix_timing #(
        .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W),
        .SCAN_W(SCAN_W), .GLYPH_W(GLYPH_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank),
        .load(load), .active(active), .col(col), .row(row), .scan(scan)
    );

    assign fb_addr = {row, col};

    textpix_fbuf #(.AW(FB_AW), .DW(CODE_W)) u_fbuf (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
        .wdata(wr_data), .raddr(fb_addr), .rdata(code_q)
    );

    textpix_glyph #(.CODE_W(CODE_W), .SCAN_W(SCAN_W), .GLYPH_W(GLYPH_W)) u_glyph (
        .set_sel(charset_sel), .code(code_q), .scan(scan), .bits(glyph)
    );

    assign glyph_addr = {charset_sel, code_q, scan};

    textpix_shift #(.GLYPH_W(GLYPH_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .active(active),
        .hblank(hblank), .vblank(vblank), .glyph(glyph), .pix(pix)
    );

    assign load_n = !load;

endmodule

// File: rtl/textpix_chk.sv
module textpix_chk #(
    parameter int COLS   = 80,
    parameter int ROWS   = 30,
    parameter int COL_W  = 7,
    parameter int ROW_W  = 5,
    parameter int SCAN_W = 4,
    parameter int FB_AW  = 12,
    parameter int GA_W   = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hblank,
    input logic             vblank,
    input logic             pix,
    input logic             load_n,
    input logic [FB_AW-1:0] fb_addr,
    input logic [GA_W-1:0]  glyph_addr
);

    logic [COL_W-1:0]  col_now;
    logic [ROW_W-1:0]  row_now;
    logic [SCAN_W-1:0] scan_now;

    assign col_now  = fb_addr[COL_W-1:0];
    assign row_now  = fb_addr[FB_AW-1:COL_W];
    assign scan_now = glyph_addr[SCAN_W-1:0];

    // R3
    load_advances_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (col_now == (($past(col_now) == COL_W'(COLS - 1)) ? '0 : $past(col_now) + 1'b1))
                    && (row_now == $past(row_now)));

    // R2
    addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !hblank && !vblank) |=> $stable(fb_addr));

    // R8
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank || vblank) |-> !pix);

    // R8
    vblank_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> load_n);

    // R6
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_now != $past(scan_now)) |-> (scan_now == $past(scan_now) + 1'b1));

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_now != $past(row_now)) |->
            (row_now == (($past(row_now) == ROW_W'(ROWS - 1)) ? '0 : $past(row_now) + 1'b1)));

    // R7
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_now < ROW_W'(ROWS));

endmodule

bind textpix_top textpix_chk #(
    .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W),
    .SCAN_W(SCAN_W), .FB_AW(FB_AW), .GA_W(GA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank),
    .pix(pix), .load_n(load_n), .fb_addr(fb_addr), .glyph_addr(glyph_addr)
);

// File: tb/textpix_top_test.sv
`timescale 1ns/1ps
module textpix_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hblank = 1'b1;
    logic        vblank = 1'b0;
    logic        charset_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        pix;
    logic        load_n;
    logic [11:0] fb_addr;
    logic [12:0] glyph_addr;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] mem_m [4096];
    logic [4:0] row_m = '0;
    logic [3:0] scan_m = '0;

    always #10 clk = !clk;

    textpix_top uut (
        .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank),
        .charset_sel(charset_sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix(pix), .load_n(load_n),
        .fb_addr(fb_addr), .glyph_addr(glyph_addr)
    );

    function automatic logic [7:0] glyph_exp(input logic s, input logic [7:0] code,
                                             input logic [3:0] line);
        if (s) return {code[3:0], code[7:4]} ^ {4'h0, line};
        return code ^ {line, line};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fb_write(input logic [11:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        mem_m[a] = d;
    endtask

    // one line: 4 blank cycles, then nchars characters
    task automatic run_line(input int nchars, input bit vb, input bit coll);
        logic [7:0] cur_code;
        logic [7:0] nxt_code;
        logic [11:0] exp_fa;
        logic [12:0] exp_ga;
        int bad_pix = 0, bad_fa = 0, bad_ld = 0, bad_ga = 0, bad_coll = 0;
        int a_pix = 0, e_pix = 0, a_fa = 0, e_fa = 0, a_ga = 0, e_ga = 0;
        nxt_code = '0;
        for (int j = 0; j < 4; j++) begin
            @(posedge clk); #1;
            hblank = 1'b1; vblank = vb; wr_en = 1'b0;
        end
        @(posedge clk); #1;
        hblank = 1'b0;
        cur_code = mem_m[{row_m, 7'd0}];
        @(negedge clk);
        // R3 strobe in last blank cycle, R8 dark there
        chk(load_n == !(!vb), "R3 pre-start strobe", int'(load_n), int'(vb));
        chk(pix == 1'b0, "R8 last blank cycle dark", int'(pix), 0);
        for (int p = 0; p < 8 * nchars; p++) begin
            int k = p / 8;
            int ph = p % 8;
            logic [11:0] nxt_a;
            nxt_a = {row_m, 7'((k + 1) % 80)};
            @(posedge clk); #1;
            wr_en = 1'b0;
            if (ph == 6) nxt_code = mem_m[nxt_a];
            if (coll && k == 10 && ph == 6) fb_write(nxt_a, ~mem_m[nxt_a]);
            if (coll && k == 20 && ph == 5) fb_write(nxt_a, ~mem_m[nxt_a]);
            @(negedge clk);
            if (vb) begin
                if (pix != 1'b0) bad_pix++;
                if (load_n != 1'b1) bad_ld++;
                if (fb_addr != {row_m, 7'd0}) begin bad_fa++; a_fa = fb_addr; e_fa = {row_m, 7'd0}; end
            end else begin
                logic eb;
                eb = glyph_exp(charset_sel, cur_code, scan_m)[7 - ph];
                if (pix != eb) begin
                    bad_pix++; a_pix = p; e_pix = eb;
                    if (k == 11 || k == 21) bad_coll++;
                end
                if (load_n != (ph != 7)) bad_ld++;
                if (ph == 3) begin
                    exp_fa = nxt_a;
                    exp_ga = {charset_sel, mem_m[nxt_a], scan_m};
                    if (fb_addr != exp_fa) begin bad_fa++; a_fa = fb_addr; e_fa = exp_fa; end
                    if (glyph_addr != exp_ga) begin bad_ga++; a_ga = glyph_addr; e_ga = exp_ga; end
                end
                if (ph == 7) cur_code = nxt_code;
            end
        end
        if (vb) begin
            chk(bad_pix == 0, "R8 vblank pixels dark", bad_pix, 0);
            chk(bad_ld == 0, "R8 vblank no load", bad_ld, 0);
            chk(bad_fa == 0, "R8 vblank column held at 0", a_fa, e_fa);
        end else if (nchars > 0) begin
            chk(bad_pix == 0, "R4 R5 R10 pixel stream", bad_pix, 0);
            if (bad_pix != 0) $display("  first bad pixel index %0d expected bit %0d", a_pix, e_pix);
            chk(bad_ld == 0, "R3 load strobe timing", bad_ld, 0);
            chk(bad_fa == 0, "R2 fetch address", a_fa, e_fa);
            chk(bad_ga == 0, "R5 glyph index", a_ga, e_ga);
            if (coll) chk(bad_coll == 0, "R9 write versus fetch", bad_coll, 0);
            {row_m, scan_m} = (scan_m == 4'd15)
                ? {((row_m == 5'd29) ? 5'd0 : row_m + 5'd1), 4'd0}
                : {row_m, scan_m + 4'd1};
        end
    endtask

    task automatic peek(input logic [4:0] er, input logic [3:0] es, input string req);
        @(posedge clk); #1; hblank = 1'b1; vblank = 1'b0; wr_en = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(fb_addr[11:7] == er, req, int'(fb_addr[11:7]), int'(er));
        chk(glyph_addr[3:0] == es, req, int'(glyph_addr[3:0]), int'(es));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pix == 1'b0, "R1 pix", int'(pix), 0);
        chk(load_n == 1'b1, "R1 load_n", int'(load_n), 1);
        chk(fb_addr == 12'd0, "R1 fb_addr", int'(fb_addr), 0);
        chk(glyph_addr[3:0] == 4'd0, "R1 scan", int'(glyph_addr[3:0]), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        for (int a = 0; a < 4096; a++) begin
            @(posedge clk); #1;
            fb_write(12'(a), 8'((a * 37 + 11) & 255));
        end
        @(posedge clk); #1; wr_en = 1'b0;
        run_line(80, 1'b0, 1'b0);          // line 0
        run_line(80, 1'b0, 1'b1);          // line 1, R9 collisions
        run_line(10, 1'b1, 1'b0);          // vblank line
        peek(5'd0, 4'd2, "R8 counters held in vblank");
        charset_sel = 1'b1;
        run_line(80, 1'b0, 1'b0);          // line 2, second set
        charset_sel = 1'b0;
        for (int l = 3; l < 16; l++) run_line(2, 1'b0, 1'b0);
        peek(5'd1, 4'd0, "R6 scan wrap advances row");
        run_line(80, 1'b0, 1'b0);          // line 16
        for (int l = 17; l < 479; l++) run_line(2, 1'b0, 1'b0);
        run_line(80, 1'b0, 1'b0);          // line 479: row 29 scan 15
        peek(5'd0, 4'd0, "R7 row wrap");
        run_line(80, 1'b0, 1'b0);          // line 480
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule